// File: doc/BRIEF.md
# Multicast Hash Destination Filter

This block sits on the receive path of an Ethernet MAC and decides whether a frame is kept, looking only at the frame's 48-bit destination address. Bytes arrive one per cycle on a byte stream. A start strobe, given together with the byte-valid strobe, marks the first destination byte. While the six address bytes stream in, the block captures them and runs a CRC-32 over them. One cycle after the sixth byte it pulses a done strobe and presents a keep/drop verdict.

A frame is kept in three cases. Its destination equals the programmed station address. Its destination is the all-ones broadcast address. Or its destination is a multicast address whose 6-bit hash selects a set bit in a 64-bit table. The table is supplied as two 32-bit words. The station address and the table words are plain register inputs that software drives. Frame storage, FCS checking and the rest of the MAC live elsewhere.

Top module: `mcast_hash_filter`

## Requirements
- R1: While reset is applied, and after it is released until the first decision, `done_o` and `accept_o` are both 0.
- R2: `done_o` is high for exactly one cycle. That cycle is the one after the clock edge that takes the sixth destination byte of a frame. A frame produces exactly one pulse.
- R3: A frame begins on a cycle where `sof_i` and `byte_vld_i` are both 1. The first received byte sits at bits [7:0] of `station_lo_i`, the second at [15:8], the third at [23:16] and the fourth at [31:24]. The fifth byte sits at bits [7:0] of `station_hi_i` and the sixth at [15:8]. A destination equal to this address is accepted.
- R4: A destination that is not multicast, is not broadcast and differs from the station address in any bit is rejected.
- R5: A destination is multicast when bit 0 of its first byte is 1. For such a destination, the hash is formed as follows. A 32-bit CRC register starts at all ones. It takes the six bytes in order, each byte least significant bit first. On every bit the register shifts left by one, and it is XORed with 0x04C11DB7 when its old bit 31 differs from the data bit. No final inversion is applied. The hash k is bits 31..26 of the result. The frame is accepted when table bit k is 1: bit k of `hash_lo_i` for k < 32, and bit k-32 of `hash_hi_i` otherwise.
- R6: With both hash words zero, no multicast destination is accepted unless it is broadcast.
- R7: The destination FF:FF:FF:FF:FF:FF is accepted whatever the table and station address hold.
- R8: The filter ignores three kinds of byte. It ignores bytes with `byte_vld_i` low. It ignores valid bytes that arrive without a preceding start of frame. It ignores valid bytes after the sixth. None of these advance the address or produce a done pulse.
- R9: A start of frame inside the address restarts capture. The verdict then depends only on the six bytes that follow the newest start.
- R10: `accept_o` holds its value from one done pulse to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sof_i | input | 1 | First destination byte marker, qualified by byte_vld_i |
| byte_vld_i | input | 1 | Byte valid strobe |
| byte_i | input | 8 | Received byte |
| station_lo_i | input | 32 | Station address bytes one to four, first byte least significant |
| station_hi_i | input | 16 | Station address bytes five and six |
| hash_lo_i | input | 32 | Hash table bits 0 to 31 |
| hash_hi_i | input | 32 | Hash table bits 32 to 63 |
| done_o | output | 1 | One-cycle pulse when the verdict is ready |
| accept_o | output | 1 | Verdict: 1 keeps the frame, 0 drops it |

## Verification
The assertions assume several things about the inputs. The strobes are never unknown after reset. `sof_i` matters only together with `byte_vld_i`. The station and table inputs are steady on the edge that takes the sixth byte. The bench changes inputs only on falling edges and keeps the configuration fixed for the whole of each frame, so these assumptions hold. Under them the checker requires four things: every done pulse is a single cycle, it follows a cycle with a valid byte, it needs some start of frame since reset, and the verdict never moves between pulses.

// File: rtl/mhf_pkg.sv
`timescale 1ns/1ps
package mhf_pkg;
  localparam int CRC_W = 32;
  typedef logic [CRC_W-1:0] crc_t;

  // One serial CRC step: shift left, fold in the generator on a mismatch.
  function automatic crc_t crc_bit_step(input crc_t c, input logic d, input crc_t poly);
    crc_t s;
    s = {c[CRC_W-2:0], 1'b0};
    if (c[CRC_W-1] ^ d) s = s ^ poly;
    return s;
  endfunction
endpackage

// File: rtl/mhf_frame_ctl.sv
`timescale 1ns/1ps
module mhf_frame_ctl #(
  parameter int ADDR_BYTES = 6,
  localparam int IDX_W = $clog2(ADDR_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sof_i,
  input  logic             byte_vld_i,
  output logic             take_o,
  output logic             first_o,
  output logic             last_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] cnt_q, cnt_nxt;
  logic             active_q, active_nxt;

  always_comb begin
    first_o    = sof_i & byte_vld_i;
    take_o     = first_o | (byte_vld_i & active_q);
    idx_o      = first_o ? '0 : cnt_q;
    last_o     = take_o & (idx_o == IDX_W'(ADDR_BYTES - 1));
    cnt_nxt    = cnt_q;
    active_nxt = active_q;
    if (take_o) begin
      cnt_nxt    = idx_o + IDX_W'(1);
      active_nxt = ~last_o;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (take_o) begin
      cnt_q    <= cnt_nxt;
      active_q <= active_nxt;
    end
  end
endmodule

// File: rtl/mhf_addr_cap.sv
`timescale 1ns/1ps
module mhf_addr_cap #(
  parameter int ADDR_BYTES = 6,
  localparam int IDX_W  = $clog2(ADDR_BYTES + 1),
  localparam int ADDR_W = 8 * ADDR_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [7:0]        byte_i,
  output logic [ADDR_W-1:0] addr_now_o
);
  logic [ADDR_W-1:0] addr_q;

  // Current address with the incoming byte merged at its slot.
  always_comb begin
    addr_now_o = addr_q;
    for (int i = 0; i < ADDR_BYTES; i++) begin
      if (idx_i == IDX_W'(i)) addr_now_o[8*i +: 8] = byte_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      addr_q <= '0;
    else if (take_i) addr_q <= addr_now_o;
  end
endmodule

// File: rtl/mhf_crc_unit.sv
`timescale 1ns/1ps
module mhf_crc_unit #(
  parameter mhf_pkg::crc_t CRC_POLY = 32'h04C11DB7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take_i,
  input  logic          first_i,
  input  logic [7:0]    byte_i,
  output mhf_pkg::crc_t crc_now_o
);
  mhf_pkg::crc_t crc_q;
  mhf_pkg::crc_t chain [0:8];

  assign chain[0] = first_i ? '1 : crc_q;

  for (genvar g = 0; g < 8; g++) begin : g_bit
    assign chain[g+1] = mhf_pkg::crc_bit_step(chain[g], byte_i[g], CRC_POLY);
  end

  assign crc_now_o = chain[8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= '1;
    else if (take_i) crc_q <= crc_now_o;
  end
endmodule

// File: rtl/mhf_decide.sv
`timescale 1ns/1ps
module mhf_decide #(
  parameter int ADDR_BYTES = 6,
  parameter int WORD_W     = 32,
  localparam int ADDR_W    = 8 * ADDR_BYTES,
  localparam int HI_W      = ADDR_W - WORD_W,
  localparam int TABLE_W   = 2 * WORD_W,
  localparam int HASH_BITS = $clog2(TABLE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              last_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  mhf_pkg::crc_t     crc_i,
  input  logic [WORD_W-1:0] station_lo_i,
  input  logic [HI_W-1:0]   station_hi_i,
  input  logic [WORD_W-1:0] hash_lo_i,
  input  logic [WORD_W-1:0] hash_hi_i,
  output logic              done_o,
  output logic              accept_o
);
  logic [HASH_BITS-1:0] hash_idx;
  logic [TABLE_W-1:0]   table_bits;
  logic                 is_mcast, is_bcast, is_own, hash_hit, verdict;
  logic                 done_q, done_nxt, accept_q, accept_nxt;

  always_comb begin
    hash_idx   = crc_i[mhf_pkg::CRC_W-1 -: HASH_BITS];
    table_bits = {hash_hi_i, hash_lo_i};
    is_mcast   = addr_i[0];
    is_bcast   = &addr_i;
    is_own     = (addr_i == {station_hi_i, station_lo_i});
    hash_hit   = is_mcast & table_bits[hash_idx];
    verdict    = is_bcast | is_own | hash_hit;
    done_nxt   = last_i;
    accept_nxt = last_i ? verdict : accept_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q   <= 1'b0;
      accept_q <= 1'b0;
    end else begin
      done_q <= done_nxt;
      if (last_i) accept_q <= accept_nxt;
    end
  end

  assign done_o   = done_q;
  assign accept_o = accept_q;
endmodule

// File: rtl/mcast_hash_filter.sv
`timescale 1ns/1ps
module mcast_hash_filter #(
  parameter int            ADDR_BYTES = 6,
  parameter int            WORD_W     = 32,
  parameter mhf_pkg::crc_t CRC_POLY   = 32'h04C11DB7,
  localparam int ADDR_W = 8 * ADDR_BYTES,
  localparam int HI_W   = ADDR_W - WORD_W,
  localparam int IDX_W  = $clog2(ADDR_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sof_i,
  input  logic              byte_vld_i,
  input  logic [7:0]        byte_i,
  input  logic [WORD_W-1:0] station_lo_i,
  input  logic [HI_W-1:0]   station_hi_i,
  input  logic [WORD_W-1:0] hash_lo_i,
  input  logic [WORD_W-1:0] hash_hi_i,
  output logic              done_o,
  output logic              accept_o
);
  // Reset asserts at once, releases on the clock.
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic              take, first, last;
  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] addr_now;
  mhf_pkg::crc_t     crc_now;

  mhf_frame_ctl #(.ADDR_BYTES(ADDR_BYTES)) ctl_i (
    .clk(clk), .rst_n(rst_sync_q), .sof_i(sof_i), .byte_vld_i(byte_vld_i),
    .take_o(take), .first_o(first), .last_o(last), .idx_o(idx)
  );

  mhf_addr_cap #(.ADDR_BYTES(ADDR_BYTES)) cap_i (
    .clk(clk), .rst_n(rst_sync_q), .take_i(take), .idx_i(idx),
    .byte_i(byte_i), .addr_now_o(addr_now)
  );

  mhf_crc_unit #(.CRC_POLY(CRC_POLY)) crc_i (
    .clk(clk), .rst_n(rst_sync_q), .take_i(take), .first_i(first),
    .byte_i(byte_i), .crc_now_o(crc_now)
  );

  mhf_decide #(.ADDR_BYTES(ADDR_BYTES), .WORD_W(WORD_W)) dec_i (
    .clk(clk), .rst_n(rst_sync_q), .last_i(last), .addr_i(addr_now),
    .crc_i(crc_now), .station_lo_i(station_lo_i), .station_hi_i(station_hi_i),
    .hash_lo_i(hash_lo_i), .hash_hi_i(hash_hi_i),
    .done_o(done_o), .accept_o(accept_o)
  );
endmodule

// File: rtl/mhf_chk.sv
`timescale 1ns/1ps
module mhf_chk (
  input logic clk,
  input logic rst_n,
  input logic sof_i,
  input logic byte_vld_i,
  input logic done_o,
  input logic accept_o
);
  logic seen_sof_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     seen_sof_q <= 1'b0;
    else if (sof_i && byte_vld_i)   seen_sof_q <= 1'b1;
  end

  // R2
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R2
  done_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(byte_vld_i));

  // R8
  done_needs_sof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> seen_sof_q);

  // R10
  verdict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(accept_o));
endmodule

bind mcast_hash_filter mhf_chk chk_i (
  .clk(clk), .rst_n(rst_n), .sof_i(sof_i), .byte_vld_i(byte_vld_i),
  .done_o(done_o), .accept_o(accept_o)
);

// File: tb/mcast_hash_filter_tb_top.sv
`timescale 1ns/1ps
module mcast_hash_filter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sof_i, byte_vld_i;
  logic [7:0]  byte_i;
  logic [31:0] station_lo_i, hash_lo_i, hash_hi_i;
  logic [15:0] station_hi_i;
  logic        done_o, accept_o;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  mcast_hash_filter dut_i (
    .clk(clk), .rst_n(rst_n), .sof_i(sof_i), .byte_vld_i(byte_vld_i),
    .byte_i(byte_i), .station_lo_i(station_lo_i), .station_hi_i(station_hi_i),
    .hash_lo_i(hash_lo_i), .hash_hi_i(hash_hi_i),
    .done_o(done_o), .accept_o(accept_o)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Hash index per R5, computed bit by bit from the address.
  function automatic logic [5:0] hash_of(input logic [47:0] da);
    logic [31:0] c;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < 48; i++) begin
      if (c[31] != da[i]) c = (c << 1) ^ 32'h04C11DB7;
      else                c = c << 1;
    end
    return c[31:26];
  endfunction

  function automatic logic exp_accept(input logic [47:0] da);
    logic [63:0] tbl;
    tbl = {hash_hi_i, hash_lo_i};
    if (da == 48'hFFFF_FFFF_FFFF) return 1'b1;
    if (da == {station_hi_i, station_lo_i}) return 1'b1;
    if (da[0] && tbl[hash_of(da)]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic run_frame(input logic [47:0] da, input bit gap, input string tag);
    logic e, held;
    e = exp_accept(da);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (gap && i > 0) begin
        sof_i = 1'b0; byte_vld_i = 1'b0; byte_i = 8'hA5;
        @(negedge clk);
      end
      sof_i = (i == 0); byte_vld_i = 1'b1; byte_i = da[8*i +: 8];
    end
    @(negedge clk);
    sof_i = 1'b0; byte_vld_i = 1'b0;
    check(done_o === 1'b1, "R2 done after sixth byte", 64'(done_o), 64'd1);
    check(accept_o === e, tag, 64'(accept_o), 64'(e));
    held = accept_o;
    byte_vld_i = 1'b1; byte_i = 8'hFF;
    @(negedge clk);
    check(done_o === 1'b0, "R2 single pulse", 64'(done_o), 64'd0);
    byte_i = 8'h00;
    @(negedge clk);
    byte_vld_i = 1'b0;
    check(done_o === 1'b0, "R8 trailing bytes ignored", 64'(done_o), 64'd0);
    check(accept_o === held, "R10 verdict held", 64'(accept_o), 64'(held));
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [47:0] st, da;
    bit seen;
    rst_n = 1'b1; sof_i = 1'b0; byte_vld_i = 1'b0; byte_i = 8'h00;
    station_lo_i = 32'h3322_1102; station_hi_i = 16'h5544;
    hash_lo_i = 32'h0; hash_hi_i = 32'h0;
    #2 rst_n = 1'b0;
    repeat (4) @(negedge clk);
    check(done_o === 1'b0, "R1 done in reset", 64'(done_o), 64'd0);
    check(accept_o === 1'b0, "R1 accept in reset", 64'(accept_o), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(done_o === 1'b0 && accept_o === 1'b0, "R1 after release",
          {62'd0, done_o, accept_o}, 64'd0);

    // R8: valid bytes without any start of frame
    seen = 0;
    for (int i = 0; i < 8; i++) begin
      byte_vld_i = 1'b1; byte_i = 8'(i);
      @(negedge clk);
      if (done_o) seen = 1;
    end
    byte_vld_i = 1'b0;
    @(negedge clk);
    if (done_o) seen = 1;
    check(!seen, "R8 no start no verdict", 64'(seen), 64'd0);

    st = {station_hi_i, station_lo_i};
    run_frame(st, 0, "R3 station match");
    run_frame(st, 1, "R3 station match with gaps R8");
    for (int b = 0; b < 48; b++)
      run_frame(st ^ (48'd1 << b), b[0], "R4 R6 single bit mismatch rejected");
    run_frame(48'hFFFF_FFFF_FFFF, 0, "R7 broadcast with empty table");
    run_frame(48'h0000_5E00_0001, 0, "R6 multicast with empty table");

    // R5: each table bit alone, several multicast destinations
    for (int k = 0; k < 64; k++) begin
      {hash_hi_i, hash_lo_i} = 64'd1 << k;
      for (int m = 0; m < 8; m++) begin
        da = {16'h00A0 ^ 16'(m * 37), 8'(k), 8'h5E, 8'(m), 8'h01};
        run_frame(da, m[0], "R5 hash table lookup");
      end
      da = {16'h1234, 8'(k), 8'h5E, 8'h00, 8'h01};
      run_frame(da, 0, "R5 hash table lookup");
    end
    {hash_hi_i, hash_lo_i} = '1;
    run_frame(48'h0000_5E00_0001, 0, "R5 full table accepts multicast");
    run_frame(48'h0000_5E00_0000, 0, "R4 unicast ignores full table");
    {hash_hi_i, hash_lo_i} = 64'd0;
    station_lo_i = 32'h0; station_hi_i = 16'h0;
    run_frame(48'hFFFF_FFFF_FFFF, 1, "R7 broadcast with no station");

    // R9: restart in the middle of the address
    station_lo_i = 32'h3322_1102; station_hi_i = 16'h5544;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      sof_i = (i == 0); byte_vld_i = 1'b1; byte_i = 8'hFF;
    end
    run_frame(48'h5544_3322_1100, 0, "R9 restart uses new bytes only");
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      sof_i = (i == 0); byte_vld_i = 1'b1; byte_i = 8'(i + 2);
    end
    run_frame({station_hi_i, station_lo_i}, 0, "R9 restart to station");

    repeat (3) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule